// File: doc/BRIEF.md
# Atomic Read-Modify-Write Lock Controller

This block carries out one locked read-modify-write, an atomic add of an operand to a memory location. At acceptance it picks one of two ways to make the operation indivisible. The first is a cheap lock inside the cache: the line must be write-back cacheable, held exclusively and wholly contained in one line, and incoming snoops to that line are then held back while the operation runs. In every other case the block takes the expensive way and raises a system-wide bus lock, waiting for its grant before touching the data.

The block sequences the read, the modify and the write against the cache data array, which lies outside the block. It releases whichever lock it holds in the cycle after the write, and returns a one-cycle completion pulse carrying the value that was read. Snoops that were held back are kept in a small queue and forwarded afterwards in the order they arrived, so that none is lost.

Top module: `atomic_line_lock`

## Requirements
- R1: An accepted request uses the in-cache lock, and raises no `bus_lock_req`, exactly when `req_wb`=1, `req_line_state` is Modified (3) or Exclusive (2), and the access does not cross a line. Size code 0/1/2 means 1/2/4 bytes. An access crosses a line when the byte offset within the 16-byte line plus the byte count exceeds 16.
- R2: Any request that fails R1 raises `bus_lock_req`. This covers a Shared (1) or Invalid (0) line, a non-cacheable access and a line-crossing access.
- R3: On the bus-lock path, `arr_rd_en` rises only in a cycle after one in which `bus_lock_gnt` was seen high. `bus_lock_req` stays high through the read and the write.
- R4: The read strobe `arr_rd_en` is followed exactly two cycles later by the write strobe `arr_wr_en`. The write data is (read data + operand), truncated to the access size in the low bytes.
- R5: In the cycle after the write, `done` pulses for one cycle and `done_old` carries the read data truncated to the access size. In that same cycle the bus lock and the snoop hold are both already released.
- R6: While an in-cache operation is between its read and its write, a snoop to the locked line gets `snp_stall`=1 and is not forwarded. On the bus-lock path, snoops are never held.
- R7: When the hold queue is empty, a snoop to any other line, or any snoop in the acceptance cycle, is forwarded on `snp_out_*` in the cycle it arrives.
- R8: Held snoops are forwarded one per cycle after release, in arrival order, and none is dropped. A snoop arriving while the queue is non-empty is also held behind the earlier ones.
- R9: `req_ready` is low while an operation is in progress or while any held snoop remains in the queue.
- R10: After reset, `req_ready`=1 and `arr_rd_en`, `arr_wr_en`, `bus_lock_req` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4 bytes |
| req_wb | input | 1 | Region is write-back cacheable |
| req_line_state | input | 2 | Coherence state of the line: I=0, S=1, E=2, M=3 |
| req_operand | input | DATA_W | Value to add |
| arr_rd_en | output | 1 | Read step strobe to the data array |
| arr_wr_en | output | 1 | Write step strobe to the data array |
| arr_addr | output | ADDR_W | Address for the read and the write steps |
| arr_rd_data | input | DATA_W | Read data, valid the cycle after `arr_rd_en` |
| arr_wr_data | output | DATA_W | Updated value for the write step |
| bus_lock_req | output | 1 | Global bus lock request |
| bus_lock_gnt | input | 1 | Global bus lock grant |
| snp_in_valid | input | 1 | Incoming external snoop |
| snp_in_addr | input | ADDR_W | Snoop address |
| snp_stall | output | 1 | Incoming snoop is being held |
| snp_out_valid | output | 1 | Snoop forwarded to coherence logic |
| snp_out_addr | output | ADDR_W | Forwarded snoop address |
| done | output | 1 | Completion pulse |
| done_old | output | DATA_W | Value read before the update |

## Verification
Two events can meet in one cycle: the release of the lock together with the completion pulse, and the arrival of a new snoop while earlier held snoops are still waiting. The directed test stacks held snoops during an in-cache lock, then sends another snoop exactly in the release cycle. It expects the release cycle to forward the oldest held snoop while stalling the newcomer, and then expects all of them to come out in arrival order. A second collision, a snoop to the target line in the acceptance cycle, must pass through unheld. A sweep over every combination of line state, cacheability, size and offset compares the chosen path, the step timing and the arithmetic against values the bench computes itself.

// File: rtl/atl_pkg.sv
// Package: shared encodings for the atomic lock controller.
// Assumes a four-state coherence encoding supplied by the tag pipeline.
package atl_pkg;

    // Coherence state codes as delivered with each request
    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_e;

    // Sequencer phases of one locked operation
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOCK = 3'd1,
        ST_RD   = 3'd2,
        ST_MOD  = 3'd3,
        ST_WR   = 3'd4,
        ST_REL  = 3'd5
    } seq_e;

    // Byte count for a size code
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/atl_path_sel.sv
// Module: atl_path_sel
// Decides at acceptance whether a locked operation may be kept inside the
// cache or must fall back to the global bus lock. Purely combinational.
// Assumes LINE_BYTES is a power of two and the offset is the low address bits.
module atl_path_sel
    import atl_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int END_W     = OFF_W + 4
) (
    input  logic [OFF_W-1:0] line_off,
    input  logic [1:0]       size_code,
    input  logic             wb_cacheable,
    input  logic [1:0]       line_state,
    output logic             use_bus
);

    logic [END_W-1:0] end_pos;
    logic             crosses;
    logic             owned;

    // Classify the access: line crossing, exclusive ownership, final path
    always_comb begin
        end_pos = END_W'(line_off) + END_W'(size_bytes(size_code));
        crosses = end_pos > END_W'(LINE_BYTES);
        owned   = (line_state == MESI_M) || (line_state == MESI_E);
        use_bus = !(wb_cacheable && owned && !crosses);
    end

endmodule

// File: rtl/atl_seq.sv
// Module: atl_seq
// Steps one locked operation through lock acquire, read, modify, write and
// release. Holds either the in-cache snoop block or the bus lock request for
// the whole operation and drops it in the release phase.
// Assumes array read data arrives one cycle after the read strobe.
module atl_seq
    import atl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_bus,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        start_size,
    input  logic [DATA_W-1:0] start_opnd,
    input  logic              bus_lock_gnt,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              busy,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              bus_lock_req,
    output logic              blk,
    output logic              done,
    output logic [DATA_W-1:0] done_old
);

    seq_e              state_q;
    logic              bus_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_q;
    logic [DATA_W-1:0] mask;
    logic              holding;

    // Byte-enable mask of the current access size
    always_comb begin
        mask = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (b < int'(size_bytes(size_q))) mask[b*8 +: 8] = 8'hFF;
        end
    end

    // Phase register and step ordering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= start_bus ? ST_LOCK : ST_RD;
                ST_LOCK: if (bus_lock_gnt) state_q <= ST_RD;
                ST_RD:   state_q <= ST_MOD;
                ST_MOD:  state_q <= ST_WR;
                ST_WR:   state_q <= ST_REL;
                ST_REL:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request attributes at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q  <= 1'b0;
            addr_q <= '0;
            size_q <= '0;
            opnd_q <= '0;
        end else if (start && state_q == ST_IDLE) begin
            bus_q  <= start_bus;
            addr_q <= start_addr;
            size_q <= start_size;
            opnd_q <= start_opnd;
        end
    end

    // Modify step: keep old value and compute the sum within the size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            new_q <= '0;
        end else if (state_q == ST_MOD) begin
            old_q <= arr_rd_data & mask;
            new_q <= (arr_rd_data + opnd_q) & mask;
        end
    end

    // Output decode from phase and chosen path
    always_comb begin
        holding      = (state_q == ST_RD) || (state_q == ST_MOD) || (state_q == ST_WR);
        busy         = state_q != ST_IDLE;
        arr_rd_en    = state_q == ST_RD;
        arr_wr_en    = state_q == ST_WR;
        arr_addr     = addr_q;
        arr_wr_data  = new_q;
        bus_lock_req = bus_q && (holding || state_q == ST_LOCK);
        blk          = !bus_q && holding;
        done         = state_q == ST_REL;
        done_old     = old_q;
    end

endmodule

// File: rtl/atl_snoop_q.sv
// Module: atl_snoop_q
// Holds external snoops aimed at the locked line while the in-cache block is
// active, and forwards held snoops in arrival order once it drops. Any snoop
// arriving while older ones wait is queued behind them to keep the order.
// Assumes the lock lasts few enough cycles that DEPTH entries never overflow.
module atl_snoop_q #(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 4,
    parameter int DEPTH   = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_in_valid,
    input  logic [ADDR_W-1:0] snp_in_addr,
    input  logic              blk,
    input  logic [LINE_W-1:0] lock_line,
    output logic              snp_stall,
    output logic              snp_out_valid,
    output logic [ADDR_W-1:0] snp_out_addr,
    output logic [CNT_W-1:0]  cnt
);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              nonempty;
    logic              hold;
    logic              push;
    logic              pop;

    // Hold and forward decisions
    always_comb begin
        nonempty      = cnt_q != '0;
        hold          = nonempty || (blk && snp_in_addr[ADDR_W-1:OFF_W] == lock_line);
        push          = snp_in_valid && hold;
        pop           = nonempty && !blk;
        snp_stall     = push;
        snp_out_valid = pop || (snp_in_valid && !hold);
        snp_out_addr  = pop ? slot_q[rd_ptr_q] : snp_in_addr;
        cnt           = cnt_q;
    end

    // Pointer and occupancy bookkeeping of the ring
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Snoop address storage
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= snp_in_addr;
    end

endmodule

// File: rtl/atomic_line_lock.sv
// Module: atomic_line_lock (top)
// Accepts one locked add at a time, chooses in-cache locking or the global
// bus lock, sequences read/modify/write on the data array and holds back
// snoops to the locked line. Assumes the coherence state and cacheability
// presented with the request are current in the acceptance cycle.
module atomic_line_lock #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SNQ_DEPTH  = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(SNQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_wb,
    input  logic [1:0]        req_line_state,
    input  logic [DATA_W-1:0] req_operand,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              bus_lock_req,
    input  logic              bus_lock_gnt,
    input  logic              snp_in_valid,
    input  logic [ADDR_W-1:0] snp_in_addr,
    output logic              snp_stall,
    output logic              snp_out_valid,
    output logic [ADDR_W-1:0] snp_out_addr,
    output logic              done,
    output logic [DATA_W-1:0] done_old
);

    logic             use_bus;
    logic             busy;
    logic             blk;
    logic             fire;
    logic [CNT_W-1:0] snq_cnt;

    // Accept only when idle and no held snoop is pending
    always_comb begin
        req_ready = !busy && (snq_cnt == '0);
        fire      = req_valid && req_ready;
    end

    atl_path_sel #(.LINE_BYTES(LINE_BYTES)) u_sel (
        .line_off     (req_addr[OFF_W-1:0]),
        .size_code    (req_size),
        .wb_cacheable (req_wb),
        .line_state   (req_line_state),
        .use_bus      (use_bus)
    );

    atl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (fire),
        .start_bus    (use_bus),
        .start_addr   (req_addr),
        .start_size   (req_size),
        .start_opnd   (req_operand),
        .bus_lock_gnt (bus_lock_gnt),
        .arr_rd_data  (arr_rd_data),
        .busy         (busy),
        .arr_rd_en    (arr_rd_en),
        .arr_wr_en    (arr_wr_en),
        .arr_addr     (arr_addr),
        .arr_wr_data  (arr_wr_data),
        .bus_lock_req (bus_lock_req),
        .blk          (blk),
        .done         (done),
        .done_old     (done_old)
    );

    atl_snoop_q #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEPTH(SNQ_DEPTH)) u_snq (
        .clk           (clk),
        .rst_n         (rst_n),
        .snp_in_valid  (snp_in_valid),
        .snp_in_addr   (snp_in_addr),
        .blk           (blk),
        .lock_line     (arr_addr[ADDR_W-1:OFF_W]),
        .snp_stall     (snp_stall),
        .snp_out_valid (snp_out_valid),
        .snp_out_addr  (snp_out_addr),
        .cnt           (snq_cnt)
    );

endmodule

// File: rtl/atl_checker.sv
// Module: atl_checker
// Temporal properties of the atomic lock controller, bound into the top.
module atl_checker #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             arr_rd_en,
    input logic             arr_wr_en,
    input logic             bus_lock_req,
    input logic             bus_lock_gnt,
    input logic             done,
    input logic             blk,
    input logic             snp_stall,
    input logic             snp_out_valid,
    input logic [CNT_W-1:0] snq_cnt
);

    AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en && bus_lock_req) |-> $past(bus_lock_gnt)); // R3
    AST_WR_TWO_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> $past(arr_rd_en, 2)); // R4
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(arr_wr_en)); // R5
    AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_lock_req && !blk)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (snq_cnt == CNT_W'(DEPTH) && snp_stall) |-> snp_out_valid); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!blk && !bus_lock_req && !arr_wr_en)); // R9

endmodule

bind atomic_line_lock atl_checker #(.DEPTH(SNQ_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .arr_rd_en     (arr_rd_en),
    .arr_wr_en     (arr_wr_en),
    .bus_lock_req  (bus_lock_req),
    .bus_lock_gnt  (bus_lock_gnt),
    .done          (done),
    .blk           (blk),
    .snp_stall     (snp_stall),
    .snp_out_valid (snp_out_valid),
    .snq_cnt       (snq_cnt)
);

// File: tb/tb_atomic_line_lock.sv
module tb_atomic_line_lock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_wb = 1'b0;
    logic [1:0]  req_line_state = '0;
    logic [31:0] req_operand = '0;
    logic        arr_rd_en, arr_wr_en;
    logic [15:0] arr_addr;
    logic [31:0] arr_rd_data = '0;
    logic [31:0] arr_wr_data;
    logic        bus_lock_req;
    logic        bus_lock_gnt = 1'b0;
    logic        snp_in_valid = 1'b0;
    logic [15:0] snp_in_addr = '0;
    logic        snp_stall, snp_out_valid;
    logic [15:0] snp_out_addr;
    logic        done;
    logic [31:0] done_old;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    atomic_line_lock dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] addr, input logic [1:0] sz, input bit wb,
                          input logic [1:0] st, input logic [31:0] opnd,
                          input logic [31:0] rdv, input int gdly);
        int nb = 1 << sz;
        bit exp_bus = !(wb && st >= 2 && (int'(addr[3:0]) + nb) <= 16);
        logic [31:0] mask = (sz == 2) ? 32'hFFFF_FFFF : ((32'h1 << (8 << sz)) - 1);
        bit saw_lock = 0, rd_lock = 0, wr_lock = 0, done_lock = 1;
        int lock_cnt = 0, gnt_at = -1, rd_at = -1, wr_at = -1, done_at = -1;
        logic [31:0] wr_d = '0, old = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = addr; req_size = sz; req_wb = wb;
        req_line_state = st; req_operand = opnd; arr_rd_data = rdv;
        @(posedge clk); #1 req_valid = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bus_lock_req) begin
                saw_lock = 1;
                if (gnt_at < 0 && lock_cnt == gdly) begin bus_lock_gnt = 1; gnt_at = k; end
                lock_cnt++;
            end
            if (arr_rd_en) begin rd_at = k; rd_lock = bus_lock_req; end
            if (arr_wr_en) begin wr_at = k; wr_d = arr_wr_data; wr_lock = bus_lock_req; end
            if (done) begin done_at = k; old = done_old; done_lock = bus_lock_req; break; end
        end
        bus_lock_gnt = 0;
        chk(saw_lock == exp_bus, exp_bus ? "R2 bus path" : "R1 cache path", 32'(saw_lock), 32'(exp_bus));
        chk(wr_d == ((rdv + opnd) & mask), "R4 write data", wr_d, (rdv + opnd) & mask);
        chk(rd_at >= 0 && wr_at == rd_at + 2, "R4 step spacing", 32'(wr_at), 32'(rd_at + 2));
        chk(old == (rdv & mask), "R5 old value", old, rdv & mask);
        chk(done_at == wr_at + 1 && !done_lock, "R5 release", 32'(done_at), 32'(wr_at + 1));
        if (exp_bus) begin
            chk(gnt_at >= 0 && rd_at > gnt_at, "R3 read after grant", 32'(rd_at), 32'(gnt_at + 1));
            chk(rd_lock && wr_lock, "R3 lock held", {30'b0, rd_lock, wr_lock}, 32'h3);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(req_ready && !arr_rd_en && !arr_wr_en && !bus_lock_req && !done, "R10 reset",
            {27'b0, req_ready, arr_rd_en, arr_wr_en, bus_lock_req, done}, 32'h10);
        @(posedge clk); #1 rst_n = 1;

        // R1..R5 sweep over state, cacheability, size, offset
        for (int st = 0; st < 4; st++)
            for (int wb = 0; wb < 2; wb++)
                for (int sz = 0; sz < 3; sz++)
                    for (int off = 0; off < 16; off++)
                        run_op(16'h0A00 + 16'(off), 2'(sz), wb[0], 2'(st), 32'(st + 1),
                               32'hFFFF_FFF0 + 32'(off) + 32'(sz << 8), off % 3);

        // Directed: held snoops, release collision, order (R6 R7 R8 R9)
        @(posedge clk); #1;
        req_valid = 1; req_addr = 16'h1230; req_size = 2; req_wb = 1; req_line_state = 3;
        req_operand = 5; arr_rd_data = 32'h10;
        snp_in_valid = 1; snp_in_addr = 16'h1230;
        @(negedge clk);
        chk(snp_out_valid && snp_out_addr == 16'h1230 && !snp_stall, "R7 accept-cycle pass",
            32'(snp_out_addr), 32'h1230);
        @(posedge clk); #1 req_valid = 0; snp_in_addr = 16'h1238;
        @(negedge clk);
        chk(snp_stall && !snp_out_valid && arr_rd_en, "R6 line held",
            {29'b0, snp_stall, snp_out_valid, arr_rd_en}, 32'h5);
        @(posedge clk); #1 snp_in_addr = 16'h4560;
        @(negedge clk);
        chk(snp_stall && !snp_out_valid, "R8 queued behind", {30'b0, snp_stall, snp_out_valid}, 32'h2);
        @(posedge clk); #1 snp_in_valid = 0;
        @(negedge clk);
        chk(arr_wr_en && !snp_out_valid && !req_ready, "R9 busy", {29'b0, arr_wr_en, snp_out_valid, req_ready}, 32'h4);
        @(posedge clk); #1 snp_in_valid = 1; snp_in_addr = 16'h7890;
        @(negedge clk);
        chk(done && !bus_lock_req, "R5 done", {30'b0, done, bus_lock_req}, 32'h2);
        chk(snp_out_valid && snp_out_addr == 16'h1238 && snp_stall, "R8 first out",
            32'(snp_out_addr), 32'h1238);
        @(posedge clk); #1 snp_in_valid = 0;
        @(negedge clk);
        chk(snp_out_valid && snp_out_addr == 16'h4560, "R8 second out", 32'(snp_out_addr), 32'h4560);
        chk(!req_ready, "R9 queue pending", 32'(req_ready), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(snp_out_valid && snp_out_addr == 16'h7890, "R8 third out", 32'(snp_out_addr), 32'h7890);
        @(posedge clk);
        @(negedge clk);
        chk(!snp_out_valid && req_ready, "R9 ready again", {30'b0, snp_out_valid, req_ready}, 32'h1);

        // Other line passes during in-cache lock (R7)
        @(posedge clk); #1;
        req_valid = 1; req_addr = 16'h2200; req_line_state = 2;
        @(posedge clk); #1 req_valid = 0; snp_in_valid = 1; snp_in_addr = 16'h3300;
        @(negedge clk);
        chk(arr_rd_en && snp_out_valid && !snp_stall && snp_out_addr == 16'h3300,
            "R7 other line pass", 32'(snp_out_addr), 32'h3300);
        @(posedge clk); #1 snp_in_valid = 0;
        repeat (4) @(posedge clk);

        // Bus-lock path never holds snoops (R6)
        #1 bus_lock_gnt = 1;
        req_valid = 1; req_addr = 16'h5500; req_line_state = 1;
        @(posedge clk); #1 req_valid = 0; snp_in_valid = 1; snp_in_addr = 16'h5504;
        @(negedge clk);
        chk(bus_lock_req && snp_out_valid && !snp_stall, "R6 bus path no hold",
            {30'b0, snp_out_valid, snp_stall}, 32'h2);
        @(posedge clk); #1 snp_in_valid = 0;
        @(negedge clk);
        chk(arr_rd_en && bus_lock_req, "R3 read under lock", {30'b0, arr_rd_en, bus_lock_req}, 32'h3);
        repeat (4) @(posedge clk);
        #1 bus_lock_gnt = 0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule